// File: doc/BRIEF.md
# SPI Flash Transaction Monitor

This block watches the byte stream of a SPI link to a serial NOR flash without ever driving it. A front end that already deserialises bits delivers one strobe for each byte carrying both the MOSI and MISO byte, plus one-cycle pulses for chip-select assertion and deassertion. The monitor uses the first byte of each transaction to pick a command class. It then steps through that command's byte phases: a three-byte address, payload bytes, or identification response bytes.

When chip select is released, the monitor emits one record in a single cycle. The record holds the opcode, the command class, the collected address, a byte count, the device ID byte where one was read, and five error flags. Across transactions it tracks whether a write-enable command was seen, so it can flag program and erase commands issued without one. There is no backpressure: a consumer must take the record in the cycle `rec_vld` is high.

Top module: `spi_flash_txn_monitor`

## Requirements
- R1: After reset, `rec_vld` is low and the tracked write enable is clear.
- R2: In the cycle after a `cs_end` pulse, a transaction that carried at least one byte produces a `rec_vld` pulse exactly one cycle long. A transaction with no byte produces no record.
- R3: `rec_class` encodes the opcode: 0 unknown; 1 control (0x06, 0x04, 0xB9); 2 read (0x03); 3 page program (0x02); 4 sector erase (0x20); 5 chip erase (0x60 or 0xC7); 6 read ID (0x9F). `rec_opcode` is the first byte.
- R4: An unrecognised opcode sets `rec_err[0]`. The rest of that transaction is ignored, so `rec_addr` and `rec_count` report 0.
- R5: For read, program and sector erase, the three MOSI bytes after the opcode form `rec_addr`, most significant byte first. Commands without an address report 0.
- R6: For program, `rec_count` counts the MOSI bytes after the address. For read, it counts the MISO bytes after the address. Sector erase and control commands report 0.
- R7: A program whose payload exceeds 256 bytes sets `rec_err[3]`. Exactly 256 bytes does not.
- R8: A sector erase whose full address is not a multiple of 4096 sets `rec_err[2]`.
- R9: For read ID, `rec_count` counts response bytes up to 3 and `rec_devid` is the third MISO byte. Later bytes are ignored. Other commands report `rec_devid` 0.
- R10: `rec_err[1]` flags a short transaction: fewer than 3 address bytes, no payload byte for read or program, or fewer than 3 read-ID responses.
- R11: `rec_err[4]` is set for a program, sector erase or chip erase when no 0x06 record has arrived since the last 0x04, program or erase record. A 0x06 record sets the tracked enable. A 0x04 record clears it, and so does any program or erase record.
- R12: Bytes strobed while no transaction is open are ignored and do not affect the next record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_start | input | 1 | One-cycle pulse: chip select asserted |
| cs_end | input | 1 | One-cycle pulse: chip select released |
| byte_vld | input | 1 | A byte pair is present this cycle |
| mosi_byte | input | 8 | Byte sent by the host |
| miso_byte | input | 8 | Byte returned by the flash |
| rec_vld | output | 1 | Record valid, one-cycle pulse |
| rec_opcode | output | 8 | Opcode of the finished command |
| rec_class | output | 3 | Command class code |
| rec_addr | output | 24 | Collected address |
| rec_count | output | CNT_W | Payload or response byte count |
| rec_devid | output | 8 | Third read-ID response byte |
| rec_err | output | 5 | bit0 unknown, bit1 short, bit2 misaligned, bit3 page overrun, bit4 no write enable |

## Verification
Every record field is registered once after the `cs_end` pulse. The bench therefore raises `cs_end` on a falling edge and reads all fields on the very next falling edge. One further falling edge later it confirms that the pulse has dropped. Bytes are driven on falling edges, one per cycle, so each byte is taken on exactly one rising edge. The write-enable state is never read directly: it is observed only through `rec_err[4]` of a later program or erase record.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    typedef enum logic [2:0] {
        CL_UNKNOWN = 3'd0,
        CL_CTRL    = 3'd1,
        CL_READ    = 3'd2,
        CL_PROG    = 3'd3,
        CL_SECT    = 3'd4,
        CL_CHIP    = 3'd5,
        CL_RDID    = 3'd6
    } sfm_class_e;

    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } sfm_phase_e;

    localparam int ERR_UNK  = 0;
    localparam int ERR_LEN  = 1;
    localparam int ERR_ALGN = 2;
    localparam int ERR_OVF  = 3;
    localparam int ERR_WREN = 4;
    localparam int ERR_W    = 5;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;

endpackage

// File: rtl/sfm_cmd_decode.sv
module sfm_cmd_decode
    import sfm_pkg::*;
(
    input  logic [7:0] opcode,
    output sfm_class_e cls,
    output logic       has_addr
);

    always_comb begin
        unique case (opcode)
            8'h06, 8'h04, 8'hB9: cls = CL_CTRL;
            8'h03:               cls = CL_READ;
            8'h02:               cls = CL_PROG;
            8'h20:               cls = CL_SECT;
            8'h60, 8'hC7:        cls = CL_CHIP;
            8'h9F:               cls = CL_RDID;
            default:             cls = CL_UNKNOWN;
        endcase
        has_addr = (cls == CL_READ) || (cls == CL_PROG) || (cls == CL_SECT);
    end

endmodule

// File: rtl/sfm_wren_tracker.sv
module sfm_wren_tracker
    import sfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic [7:0] opcode,
    input  sfm_class_e cls,
    output logic       wren
);

    logic wren_d, wren_q;

    always_comb begin
        wren_d = wren_q;
        if (upd) begin
            if (opcode == OP_WREN) begin
                wren_d = 1'b1;
            end else if (opcode == OP_WRDI) begin
                wren_d = 1'b0;
            end else if (cls == CL_PROG || cls == CL_SECT || cls == CL_CHIP) begin
                wren_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wren_q <= 1'b0;
        else        wren_q <= wren_d;
    end

    assign wren = wren_q;

endmodule

// File: rtl/spi_flash_txn_monitor.sv
module spi_flash_txn_monitor
    import sfm_pkg::*;
#(
    parameter int CNT_W        = 12,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    parameter int ADDR_BYTES   = 3,
    parameter int ID_BYTES     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_start,
    input  logic             cs_end,
    input  logic             byte_vld,
    input  logic [7:0]       mosi_byte,
    input  logic [7:0]       miso_byte,
    output logic             rec_vld,
    output logic [7:0]       rec_opcode,
    output logic [2:0]       rec_class,
    output logic [23:0]      rec_addr,
    output logic [CNT_W-1:0] rec_count,
    output logic [7:0]       rec_devid,
    output logic [4:0]       rec_err
);

    localparam int               ADDR_W   = 8 * ADDR_BYTES;
    localparam int               ABYTE_W  = $clog2(ADDR_BYTES + 1);
    localparam int               SECT_LSB = $clog2(SECTOR_BYTES);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PAGE_LIM = CNT_W'(PAGE_BYTES);
    localparam logic [CNT_W-1:0] ID_LAST  = CNT_W'(ID_BYTES - 1);
    localparam logic [CNT_W-1:0] ID_LIM   = CNT_W'(ID_BYTES);
    localparam logic [ABYTE_W-1:0] ADDR_FULL = ABYTE_W'(ADDR_BYTES);

    typedef struct packed {
        logic               active;
        logic               got_op;
        sfm_phase_e         phase;
        logic [7:0]         opcode;
        sfm_class_e         cls;
        logic [ADDR_W-1:0]  addr;
        logic [ABYTE_W-1:0] abytes;
        logic [CNT_W-1:0]   count;
        logic [7:0]         devid;
        logic               unk;
        logic               ovf;
        logic               rec_vld;
        logic [7:0]         rec_op;
        sfm_class_e         rec_cls;
        logic [ADDR_W-1:0]  rec_addr;
        logic [CNT_W-1:0]   rec_cnt;
        logic [7:0]         rec_devid;
        logic [ERR_W-1:0]   rec_err;
    } st_t;

    st_t        st_d, st_q;
    sfm_class_e dec_cls;
    logic       dec_addr;
    logic [7:0] dec_op;
    logic       wren;
    logic       emit;
    logic       len_err;
    logic       misal;
    logic       no_wren;

    assign dec_op = (st_q.phase == PH_OPC) ? mosi_byte : st_q.opcode;

    sfm_cmd_decode dec_i (
        .opcode   (dec_op),
        .cls      (dec_cls),
        .has_addr (dec_addr)
    );

    sfm_wren_tracker wren_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (emit),
        .opcode (st_d.opcode),
        .cls    (st_d.cls),
        .wren   (wren)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rec_vld = 1'b0;
        emit         = 1'b0;
        len_err      = 1'b0;
        misal        = 1'b0;
        no_wren      = 1'b0;

        // byte phase sequencing
        if (st_q.active && byte_vld) begin
            unique case (st_q.phase)
                PH_OPC: begin
                    st_d.opcode = mosi_byte;
                    st_d.cls    = dec_cls;
                    st_d.got_op = 1'b1;
                    if (dec_cls == CL_UNKNOWN) begin
                        st_d.unk   = 1'b1;
                        st_d.phase = PH_DONE;
                    end else if (dec_addr) begin
                        st_d.phase = PH_ADDR;
                    end else if (dec_cls == CL_RDID) begin
                        st_d.phase = PH_DATA;
                    end else begin
                        st_d.phase = PH_DONE;
                    end
                end
                PH_ADDR: begin
                    st_d.addr   = {st_q.addr[ADDR_W-9:0], mosi_byte};
                    st_d.abytes = st_q.abytes + 1'b1;
                    if (st_q.abytes == ADDR_FULL - 1'b1) begin
                        st_d.phase = (st_q.cls == CL_SECT) ? PH_DONE : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (st_q.count != CNT_MAX) st_d.count = st_q.count + 1'b1;
                    if (st_q.cls == CL_PROG && st_q.count >= PAGE_LIM) st_d.ovf = 1'b1;
                    if (st_q.cls == CL_RDID && st_q.count == ID_LAST) begin
                        st_d.devid = miso_byte;
                        st_d.phase = PH_DONE;
                    end
                end
                default: ;
            endcase
        end

        // close the transaction and build the record
        if (st_q.active && cs_end) begin
            st_d.active = 1'b0;
            if (st_d.got_op) begin
                emit = 1'b1;
                unique case (st_d.cls)
                    CL_READ, CL_PROG: len_err = (st_d.abytes != ADDR_FULL) || (st_d.count == '0);
                    CL_SECT:          len_err = (st_d.abytes != ADDR_FULL);
                    CL_RDID:          len_err = (st_d.count < ID_LIM);
                    default:          len_err = 1'b0;
                endcase
                misal   = (st_d.cls == CL_SECT) && (st_d.abytes == ADDR_FULL) &&
                          (st_d.addr[SECT_LSB-1:0] != '0);
                no_wren = (st_d.cls == CL_PROG || st_d.cls == CL_SECT || st_d.cls == CL_CHIP) && !wren;
                st_d.rec_vld   = 1'b1;
                st_d.rec_op    = st_d.opcode;
                st_d.rec_cls   = st_d.cls;
                st_d.rec_addr  = st_d.addr;
                st_d.rec_cnt   = st_d.count;
                st_d.rec_devid = st_d.devid;
                st_d.rec_err   = '0;
                st_d.rec_err[ERR_UNK]  = st_d.unk;
                st_d.rec_err[ERR_LEN]  = len_err;
                st_d.rec_err[ERR_ALGN] = misal;
                st_d.rec_err[ERR_OVF]  = st_d.ovf;
                st_d.rec_err[ERR_WREN] = no_wren;
            end
        end

        // open a new transaction
        if (cs_start) begin
            st_d.active = 1'b1;
            st_d.got_op = 1'b0;
            st_d.phase  = PH_OPC;
            st_d.opcode = '0;
            st_d.cls    = CL_UNKNOWN;
            st_d.addr   = '0;
            st_d.abytes = '0;
            st_d.count  = '0;
            st_d.devid  = '0;
            st_d.unk    = 1'b0;
            st_d.ovf    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rec_vld    = st_q.rec_vld;
    assign rec_opcode = st_q.rec_op;
    assign rec_class  = st_q.rec_cls;
    assign rec_addr   = st_q.rec_addr[23:0];
    assign rec_count  = st_q.rec_cnt;
    assign rec_devid  = st_q.rec_devid;
    assign rec_err    = st_q.rec_err;

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker
    import sfm_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int PAGE_BYTES = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_end,
    input logic             rec_vld,
    input logic [2:0]       rec_class,
    input logic [23:0]      rec_addr,
    input logic [CNT_W-1:0] rec_count,
    input logic [4:0]       rec_err
);

    // R2: record is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rec_vld |=> !rec_vld);

    // R2: record only follows a chip-select release
    a_r2_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        rec_vld |-> $past(cs_end));

    // R4: unknown opcode yields an empty record
    a_r4_unknown_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_vld && rec_err[ERR_UNK]) |->
        (rec_class == CL_UNKNOWN && rec_count == '0 && rec_addr == '0));

    // R7: page overrun only on a program longer than a page
    a_r7_overrun_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_vld && rec_err[ERR_OVF]) |->
        (rec_class == CL_PROG && rec_count > CNT_W'(PAGE_BYTES)));

    // R8: misalignment only on sector erase
    a_r8_misalign_sect: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_vld && rec_err[ERR_ALGN]) |-> (rec_class == CL_SECT));

    // R11: missing enable only on program or erase
    a_r11_nowren_class: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_vld && rec_err[ERR_WREN]) |->
        (rec_class == CL_PROG || rec_class == CL_SECT || rec_class == CL_CHIP));

endmodule

bind spi_flash_txn_monitor sfm_checker #(
    .CNT_W      (CNT_W),
    .PAGE_BYTES (PAGE_BYTES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_end    (cs_end),
    .rec_vld   (rec_vld),
    .rec_class (rec_class),
    .rec_addr  (rec_addr),
    .rec_count (rec_count),
    .rec_err   (rec_err)
);

// File: tb/spi_flash_txn_monitor_tb_top.sv
module spi_flash_txn_monitor_tb_top;

    localparam int CNT_W = 12;
    localparam logic [2:0] C_UNK = 3'd0, C_CTRL = 3'd1, C_READ = 3'd2, C_PROG = 3'd3,
                           C_SECT = 3'd4, C_CHIP = 3'd5, C_RDID = 3'd6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_start = 1'b0;
    logic             cs_end = 1'b0;
    logic             byte_vld = 1'b0;
    logic [7:0]       mosi_byte = '0;
    logic [7:0]       miso_byte = '0;
    logic             rec_vld;
    logic [7:0]       rec_opcode;
    logic [2:0]       rec_class;
    logic [23:0]      rec_addr;
    logic [CNT_W-1:0] rec_count;
    logic [7:0]       rec_devid;
    logic [4:0]       rec_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    spi_flash_txn_monitor #(.CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_start   (cs_start),
        .cs_end     (cs_end),
        .byte_vld   (byte_vld),
        .mosi_byte  (mosi_byte),
        .miso_byte  (miso_byte),
        .rec_vld    (rec_vld),
        .rec_opcode (rec_opcode),
        .rec_class  (rec_class),
        .rec_addr   (rec_addr),
        .rec_count  (rec_count),
        .rec_devid  (rec_devid),
        .rec_err    (rec_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic txn_open();
        @(negedge clk);
        cs_start = 1'b1;
        @(negedge clk);
        cs_start = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] m, input logic [7:0] s);
        byte_vld  = 1'b1;
        mosi_byte = m;
        miso_byte = s;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic put_cmd_addr(input logic [7:0] op, input logic [23:0] a);
        put_byte(op, 8'h00);
        put_byte(a[23:16], 8'h00);
        put_byte(a[15:8], 8'h00);
        put_byte(a[7:0], 8'h00);
    endtask

    task automatic txn_close_expect(input string tag, input logic [7:0] op, input logic [2:0] cls,
                                    input logic [23:0] a, input int cnt, input logic [7:0] dev,
                                    input logic [4:0] err);
        cs_end = 1'b1;
        @(negedge clk);
        cs_end = 1'b0;
        chk({tag, " R2 vld"}, 32'(rec_vld), 32'd1);
        chk({tag, " R3 opcode"}, 32'(rec_opcode), 32'(op));
        chk({tag, " R3 class"}, 32'(rec_class), 32'(cls));
        chk({tag, " R5 addr"}, 32'(rec_addr), 32'(a));
        chk({tag, " R6 count"}, 32'(rec_count), 32'(cnt));
        chk({tag, " R9 devid"}, 32'(rec_devid), 32'(dev));
        chk({tag, " R10 err"}, 32'(rec_err), 32'(err));
        @(negedge clk);
        chk({tag, " R2 pulse end"}, 32'(rec_vld), 32'd0);
    endtask

    task automatic txn_close_none(input string tag);
        cs_end = 1'b1;
        @(negedge clk);
        cs_end = 1'b0;
        chk({tag, " R2 no record"}, 32'(rec_vld), 32'd0);
        @(negedge clk);
        chk({tag, " R2 no record late"}, 32'(rec_vld), 32'd0);
    endtask

    task automatic do_simple(input string tag, input logic [7:0] op, input logic [2:0] cls,
                             input logic [4:0] err);
        txn_open();
        put_byte(op, 8'h00);
        txn_close_expect(tag, op, cls, 24'h0, 0, 8'h00, err);
    endtask

    task automatic t_reset();
        chk("R1 reset vld", 32'(rec_vld), 32'd0);
        // R1: enable clear after reset, so an erase reports missing enable
        do_simple("R1 erase after reset", 8'h60, C_CHIP, 5'h10);
    endtask

    task automatic t_program_basic();
        do_simple("R3 wren", 8'h06, C_CTRL, 5'h00);
        txn_open();
        put_cmd_addr(8'h02, 24'h123456);
        for (int i = 0; i < 4; i++) put_byte(8'(i + 8'h41), 8'hFF);
        txn_close_expect("R6 program 4", 8'h02, C_PROG, 24'h123456, 4, 8'h00, 5'h00);
        // R11: enable consumed by the program
        txn_open();
        put_cmd_addr(8'h02, 24'h000100);
        put_byte(8'h55, 8'h00);
        txn_close_expect("R11 program no wren", 8'h02, C_PROG, 24'h000100, 1, 8'h00, 5'h10);
    endtask

    task automatic t_wrdi();
        do_simple("R11 wren", 8'h06, C_CTRL, 5'h00);
        do_simple("R11 wrdi", 8'h04, C_CTRL, 5'h00);
        do_simple("R11 chip erase after wrdi", 8'hC7, C_CHIP, 5'h10);
        do_simple("R3 deep power", 8'hB9, C_CTRL, 5'h00);
    endtask

    task automatic t_read();
        txn_open();
        put_cmd_addr(8'h03, 24'hABCDEF);
        for (int i = 0; i < 5; i++) put_byte(8'h00, 8'(8'hA0 + i));
        txn_close_expect("R6 read 5", 8'h03, C_READ, 24'hABCDEF, 5, 8'h00, 5'h00);
    endtask

    task automatic t_erase();
        do_simple("R8 wren", 8'h06, C_CTRL, 5'h00);
        txn_open();
        put_cmd_addr(8'h20, 24'h00A000);
        txn_close_expect("R8 aligned", 8'h20, C_SECT, 24'h00A000, 0, 8'h00, 5'h00);
        txn_open();
        put_cmd_addr(8'h20, 24'h00A010);
        txn_close_expect("R8 misaligned", 8'h20, C_SECT, 24'h00A010, 0, 8'h00, 5'h14);
    endtask

    task automatic t_page(input int n, input logic [4:0] err);
        do_simple("R7 wren", 8'h06, C_CTRL, 5'h00);
        txn_open();
        put_cmd_addr(8'h02, 24'h004000);
        for (int i = 0; i < n; i++) put_byte(8'(i), 8'h00);
        txn_close_expect("R7 page", 8'h02, C_PROG, 24'h004000, n, 8'h00, err);
    endtask

    task automatic t_rdid();
        txn_open();
        put_byte(8'h9F, 8'h00);
        put_byte(8'h00, 8'hC2);
        put_byte(8'h00, 8'h20);
        put_byte(8'h00, 8'h16);
        put_byte(8'h00, 8'h77);
        txn_close_expect("R9 rdid", 8'h9F, C_RDID, 24'h0, 3, 8'h16, 5'h00);
        txn_open();
        put_byte(8'h9F, 8'h00);
        put_byte(8'h00, 8'hC2);
        put_byte(8'h00, 8'h20);
        txn_close_expect("R10 rdid short", 8'h9F, C_RDID, 24'h0, 2, 8'h00, 5'h02);
    endtask

    task automatic t_unknown();
        txn_open();
        put_byte(8'h5A, 8'h00);
        put_byte(8'h12, 8'h34);
        put_byte(8'h56, 8'h78);
        put_byte(8'h9A, 8'hBC);
        put_byte(8'hDE, 8'hF0);
        txn_close_expect("R4 unknown", 8'h5A, C_UNK, 24'h0, 0, 8'h00, 5'h01);
    endtask

    task automatic t_short_read();
        txn_open();
        put_byte(8'h03, 8'h00);
        put_byte(8'h12, 8'h00);
        put_byte(8'h34, 8'h00);
        txn_close_expect("R10 read short addr", 8'h03, C_READ, 24'h001234, 0, 8'h00, 5'h02);
        txn_open();
        put_cmd_addr(8'h03, 24'h000010);
        txn_close_expect("R10 read no data", 8'h03, C_READ, 24'h000010, 0, 8'h00, 5'h02);
    endtask

    task automatic t_idle_bytes();
        txn_open();
        txn_close_none("R2 empty");
        // R12: stray bytes while no transaction is open
        put_byte(8'h03, 8'h11);
        put_byte(8'h9F, 8'h22);
        txn_open();
        put_byte(8'hB9, 8'h00);
        txn_close_expect("R12 stray ignored", 8'hB9, C_CTRL, 24'h0, 0, 8'h00, 5'h00);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program_basic();
        t_wrdi();
        t_read();
        t_erase();
        t_page(257, 5'h08);
        t_page(256, 5'h00);
        t_rdid();
        t_unknown();
        t_short_read();
        t_idle_bytes();
        repeat (3) @(negedge clk);
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

endmodule